// File: doc/BRIEF.md
# Password-protected watchdog timer

This block is a watchdog timer on a small register bus. It has two registers: a control register at offset 0x0 and a read-only status register at offset 0x8. The control register can only be changed by a pair of writes. The first write arms the block with one magic byte. The write that follows carries a second, different magic byte and the new settings. Any other write drops the armed state, so a stray or runaway store cannot start, stop or reprogram the timer.

Once enabled, a prescaler divides the clock by one of four powers of two. Each prescaler tick decrements a 16-bit counter, which is loaded from the reload field. The counter raises a one-clock pre-warning pulse when it drops to a programmable fraction of the full range. When it runs out it raises a reset request and sets a sticky reset-cause flag. Only the block's own reset clears that flag.

Software starts the timer by writing the unlock pair with the enable bit set. It services the timer by repeating the pair with a fresh reload value, and it stops the timer by repeating the pair with enable clear. A start while the timer is already running simply replaces every setting.

Top module: `pwd_wdt`

## Requirements
- R1: After the synchronous reset `rst` releases, the control register reads 0, the status register reads 0, and `warn_pulse`, `rst_req` and `rst_cause` are all low.
- R2: The control register changes only on this exact sequence: a write to offset 0x0 with 0xBE in bits 23:16, immediately followed (as the next bus write) by a write to offset 0x0 with 0xDC in bits 23:16. The settings are taken from the second write.
- R3: Any other write drops the armed state and leaves the control register unchanged. This covers a wrong magic byte, either write going to offset 0x8 or to any other offset, the bytes in reverse order, and a second 0xBE.
- R4: The control register reads back as follows: bit 31 is the enable, bits 27:26 are the pre-warning code, bits 25:24 are the divider code and bits 15:0 are the reload value. All other bits, including the password field, read 0.
- R5: The status register reads the enable in bit 31 and the live counter in bits 15:0, with all other bits 0.
- R6: While the timer is enabled, divider code d divides the clock by 2^(6+4d): 64, 1024, 16384 and 2^18 for codes 0 to 3. The first decrement lands exactly 2^(6+4d) clocks after the accepted write.
- R7: An accepted write with the enable set loads the counter from the reload field at once and restarts the prescaler, even while the timer is already running.
- R8: An accepted write with the enable clear stops the timer, and the counter then holds its value.
- R9: When the counter decrements to the threshold 0x8000 >> p (p being the pre-warning code), `warn_pulse` is high for exactly one clock. That clock starts with the same edge that shows the counter at the threshold.
- R10: When the counter decrements to 0, or a tick arrives while it is 0, `rst_req` rises together with `rst_cause`. `rst_req` stays high until the next accepted control write.
- R11: Once set, `rst_cause` stays set through later control writes, and only `rst` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| warn_pulse | output | 1 | One-clock pre-warning pulse |
| rst_req | output | 1 | Reset request after expiry |
| rst_cause | output | 1 | Sticky flag: last reset request came from this timer |

## Verification
The assertions assume that each write strobe lasts a single clock, with address and data stable and free of X while it is high. They also assume that reset is held long enough to clear every register before the first strobe. The stimulus drives the bus only on falling edges, raises the strobe for exactly one clock per write, and keeps it low between writes. It puts a neutral write to an unused offset before each table case, so an armed state left over from the previous case cannot leak into the next. Reload values and divider codes are picked so that every expected counter value, pre-warning and expiry falls on a clock edge the bench can compute from the prescaler ratio alone.

// File: rtl/pwd_wdt_pkg.sv
package pwd_wdt_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    // control word field positions
    localparam int EN_BIT = 31;
    localparam int PWL_LO = 26;
    localparam int DIV_LO = 24;
    localparam int PW_LO  = 16;
    localparam int PW_HI  = 23;

    localparam logic [7:0] PW_ARM    = 8'hBE;
    localparam logic [7:0] PW_COMMIT = 8'hDC;

    typedef enum logic {
        LK_IDLE,
        LK_ARMED
    } lock_st_e;

    typedef struct packed {
        logic             en;
        logic [1:0]       pwl;
        logic [1:0]       div;
        logic [CNT_W-1:0] reload;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w                 = '0;
        w[EN_BIT]         = c.en;
        w[PWL_LO +: 2]    = c.pwl;
        w[DIV_LO +: 2]    = c.div;
        w[CNT_W-1:0]      = c.reload;
        return w;
    endfunction

    // threshold is half the full range shifted right by the code
    function automatic logic [CNT_W-1:0] warn_thr(input logic [1:0] code);
        logic [CNT_W-1:0] half;
        half = {1'b1, {(CNT_W-1){1'b0}}};
        return half >> code;
    endfunction

endpackage

// File: rtl/pwd_wdt_unlock.sv
module pwd_wdt_unlock
    import pwd_wdt_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              accept,
    output ctrl_t             ctrl_new
);

    lock_st_e   st_q;
    logic       hit_ctrl;
    logic       arm;
    logic [7:0] pw;
    logic       unused_bits;

    assign unused_bits = ^bus_wdata[EN_BIT-1:PWL_LO+2];

    always_comb begin
        hit_ctrl = (bus_addr == CTRL_OFS);
        pw       = bus_wdata[PW_HI:PW_LO];
        arm      = bus_wr && (st_q == LK_IDLE) && hit_ctrl && (pw == PW_ARM);
        accept   = bus_wr && (st_q == LK_ARMED) && hit_ctrl && (pw == PW_COMMIT);

        ctrl_new.en     = bus_wdata[EN_BIT];
        ctrl_new.pwl    = bus_wdata[PWL_LO +: 2];
        ctrl_new.div    = bus_wdata[DIV_LO +: 2];
        ctrl_new.reload = bus_wdata[CNT_W-1:0];
    end

    // every write leaves the armed state; only a valid first write enters it
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LK_IDLE;
        end else if (bus_wr) begin
            st_q <= arm ? LK_ARMED : LK_IDLE;
        end
    end

endmodule

// File: rtl/pwd_wdt_prescale.sv
module pwd_wdt_prescale #(
    parameter int PRE_BASE = 6,
    parameter int PRE_STEP = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] div,
    output logic       tick
);

    localparam int PRE_W  = PRE_BASE + 3 * PRE_STEP;
    localparam int N_CODE = 4;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim_tbl [N_CODE];

    for (genvar g = 0; g < N_CODE; g++) begin : g_lim
        assign lim_tbl[g] = PRE_W'((64'd1 << (PRE_BASE + PRE_STEP * g)) - 64'd1);
    end

    assign tick = run && (pre_q == lim_tbl[div]);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/pwd_wdt_count.sv
module pwd_wdt_count
    import pwd_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic             clr,
    input  logic [CNT_W-1:0] load_val,
    input  logic [1:0]       pwl,
    output logic [CNT_W-1:0] cnt_q,
    output logic             warn_q,
    output logic             expired_q,
    output logic             expire_evt
);

    logic [CNT_W-1:0] thr;
    logic             step;

    always_comb begin
        thr        = warn_thr(pwl);
        step       = run && tick && !clr;
        expire_evt = step && (cnt_q <= CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            warn_q    <= 1'b0;
            expired_q <= 1'b0;
        end else if (load) begin
            cnt_q     <= load_val;
            warn_q    <= 1'b0;
            expired_q <= 1'b0;
        end else begin
            warn_q <= step && (cnt_q == thr + CNT_W'(1));
            if (step && (cnt_q != '0)) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (clr) begin
                expired_q <= 1'b0;
            end else if (expire_evt) begin
                expired_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwd_wdt.sv
module pwd_wdt
    import pwd_wdt_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(8),
    parameter int                PRE_BASE = 6,
    parameter int                PRE_STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              warn_pulse,
    output logic              rst_req,
    output logic              rst_cause
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic             accept;
    logic             load;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             expired;
    logic             expire_evt;
    logic             cause_q;

    pwd_wdt_unlock #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS)
    ) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .accept   (accept),
        .ctrl_new (ctrl_new)
    );

    assign load = accept && ctrl_new.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (accept) begin
            ctrl_q <= ctrl_new;
        end
    end

    pwd_wdt_prescale #(
        .PRE_BASE(PRE_BASE),
        .PRE_STEP(PRE_STEP)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl_q.en),
        .restart(load),
        .div    (ctrl_q.div),
        .tick   (tick)
    );

    pwd_wdt_count u_count (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.en),
        .tick      (tick),
        .load      (load),
        .clr       (accept),
        .load_val  (ctrl_new.reload),
        .pwl       (ctrl_q.pwl),
        .cnt_q     (cnt),
        .warn_q    (warn_pulse),
        .expired_q (expired),
        .expire_evt(expire_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= 1'b0;
        end else if (expire_evt) begin
            cause_q <= 1'b1;
        end
    end

    assign rst_req   = expired;
    assign rst_cause = cause_q;

    always_comb begin
        if (bus_addr == CTRL_OFS) begin
            bus_rdata = pack_ctrl(ctrl_q);
        end else if (bus_addr == STAT_OFS) begin
            bus_rdata = {ctrl_q.en, {(DATA_W-CNT_W-1){1'b0}}, cnt};
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/pwd_wdt_chk.sv
module pwd_wdt_chk
    import pwd_wdt_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_pw,
    input logic              warn,
    input logic              rst_req,
    input logic              rst_cause,
    input logic              accept,
    input ctrl_t             ctrl_q,
    input logic [CNT_W-1:0]  cnt
);

    AST_CTRL_GUARDED: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == CTRL_OFS) && (bus_pw == PW_COMMIT)) |=> $stable(ctrl_q)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ((cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) - CNT_W'(1))))); // R6

    AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !accept) |=> $stable(cnt)); // R8

    AST_WARN_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        warn |=> !warn); // R9

    AST_REQ_SETS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> rst_cause); // R10

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        rst_cause |=> rst_cause); // R11

endmodule

bind pwd_wdt pwd_wdt_chk #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_pw   (bus_wdata[pwd_wdt_pkg::PW_HI:pwd_wdt_pkg::PW_LO]),
    .warn     (warn_pulse),
    .rst_req  (rst_req),
    .rst_cause(rst_cause),
    .accept   (accept),
    .ctrl_q   (ctrl_q),
    .cnt      (cnt)
);

// File: tb/pwd_wdt_bench.sv
module pwd_wdt_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 9;
    localparam logic [31:0] BASE = 32'h0000_1111;

    // row: first addr, first data, second addr, second data, expected control readback
    localparam logic [103:0] VEC [NV] = '{
        {4'h0, 32'h00BE_0000, 4'h0, 32'h0ADC_5555, 32'h0A00_5555},
        {4'h0, 32'h00BD_0000, 4'h0, 32'h03DC_2222, BASE},
        {4'h0, 32'h00BE_0000, 4'h0, 32'h00DD_2222, BASE},
        {4'h0, 32'h00BE_0000, 4'h8, 32'h03DC_2222, BASE},
        {4'h8, 32'h00BE_0000, 4'h0, 32'h03DC_2222, BASE},
        {4'h0, 32'h00DC_2222, 4'h0, 32'h00BE_0000, BASE},
        {4'h0, 32'h00BE_0000, 4'h0, 32'h00BE_2222, BASE},
        {4'h0, 32'h00BE_0000, 4'h0, 32'h0FDC_FFFF, 32'h0F00_FFFF},
        {4'h0, 32'h00BE_0000, 4'h0, 32'h81DC_1234, 32'h8100_1234}
    };

    logic        clk;
    logic        rst;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        warn_pulse;
    logic        rst_req;
    logic        rst_cause;

    int n_checks;
    int n_fail;
    logic [31:0] rv;

    pwd_wdt u_pwd_wdt (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .warn_pulse(warn_pulse),
        .rst_req   (rst_req),
        .rst_cause (rst_cause)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 4'h4;
    endtask

    task automatic unlock(input logic [31:0] settings);
        bus_write(4'h0, 32'h00BE_0000);
        bus_write(4'h0, (settings & 32'hFF00_FFFF) | 32'h00DC_0000);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 4'h4;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        n_checks  = 0;
        n_fail    = 0;
        rst       = 1'b1;
        bus_wr    = 1'b0;
        bus_addr  = 4'h4;
        bus_wdata = '0;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(1);

        // R1 reset state
        rd(4'h0, rv); chk("R1 control after reset", rv, 32'h0);
        rd(4'h8, rv); chk("R1 status after reset", rv, 32'h0);
        chk("R1 outputs after reset", {29'd0, warn_pulse, rst_req, rst_cause}, 32'h0);

        // unlock sequence table
        for (int i = 0; i < NV; i++) begin
            bus_write(4'h4, 32'h0);
            unlock(BASE);
            bus_write(VEC[i][103:100], VEC[i][99:68]);
            bus_write(VEC[i][67:64], VEC[i][63:32]);
            rd(4'h0, rv);
            if (VEC[i][31:0] == BASE)
                chk($sformatf("R3 rejected sequence row %0d", i), rv, VEC[i][31:0]);
            else
                chk($sformatf("R2 R4 accepted sequence row %0d", i), rv, VEC[i][31:0]);
        end
        bus_write(4'h4, 32'h0);
        unlock(32'h0);

        // R6 divider code 0, R5 and R7 load
        unlock(32'h8C00_0005);
        rd(4'h8, rv); chk("R5 R7 status right after start", rv, 32'h8000_0005);
        wait_clk(63);
        rd(4'h8, rv); chk("R6 code0 no decrement at 63", rv, 32'h8000_0005);
        wait_clk(1);
        rd(4'h8, rv); chk("R6 code0 decrement at 64", rv, 32'h8000_0004);

        // R8 stop freezes counter
        unlock(32'h0C00_0005);
        rd(4'h8, rv); chk("R8 status after stop", rv, 32'h0000_0004);
        wait_clk(200);
        rd(4'h8, rv); chk("R8 counter frozen", rv, 32'h0000_0004);

        // R6 divider code 1
        unlock(32'h8D00_0003);
        wait_clk(1023);
        rd(4'h8, rv); chk("R6 code1 no decrement at 1023", rv, 32'h8000_0003);
        wait_clk(1);
        rd(4'h8, rv); chk("R6 code1 decrement at 1024", rv, 32'h8000_0002);

        // R6 divider code 3: nothing within 20000 clocks
        unlock(32'h8F00_0007);
        wait_clk(20000);
        rd(4'h8, rv); chk("R6 code3 still full after 20000", rv, 32'h8000_0007);

        // R7 service reload restarts prescaler
        unlock(32'h8C00_000A);
        wait_clk(100);
        rd(4'h8, rv); chk("R7 running before service", rv, 32'h8000_0009);
        unlock(32'h8C00_000A);
        rd(4'h8, rv); chk("R7 reloaded by service", rv, 32'h8000_000A);
        wait_clk(63);
        rd(4'h8, rv); chk("R7 prescaler restarted at 63", rv, 32'h8000_000A);
        wait_clk(1);
        rd(4'h8, rv); chk("R7 prescaler restarted at 64", rv, 32'h8000_0009);

        // R9 pre-warning, code 3
        unlock(32'h8C00_1002);
        wait_clk(64);
        chk("R9 no warning above threshold", {31'd0, warn_pulse}, 32'd0);
        wait_clk(64);
        chk("R9 warning at threshold code3", {31'd0, warn_pulse}, 32'd1);
        rd(4'h8, rv); chk("R9 counter at threshold code3", rv, 32'h8000_1000);
        wait_clk(1);
        chk("R9 warning lasts one clock", {31'd0, warn_pulse}, 32'd0);

        // R9 pre-warning, code 0
        unlock(32'h8000_8001);
        wait_clk(64);
        chk("R9 warning at threshold code0", {31'd0, warn_pulse}, 32'd1);

        // R10 expiry
        unlock(32'h8C00_0002);
        wait_clk(127);
        chk("R10 no request before zero", {30'd0, rst_req, rst_cause}, 32'd0);
        wait_clk(1);
        chk("R10 request and cause at zero", {30'd0, rst_req, rst_cause}, 32'd3);
        rd(4'h8, rv); chk("R10 counter at zero", rv, 32'h8000_0000);
        wait_clk(70);
        chk("R10 request held", {31'd0, rst_req}, 32'd1);

        // R11 cause survives control writes, cleared by reset
        unlock(32'h8C00_0100);
        chk("R10 R11 service clears request keeps cause", {30'd0, rst_req, rst_cause}, 32'd1);
        unlock(32'h0);
        chk("R11 cause kept after stop", {31'd0, rst_cause}, 32'd1);
        @(negedge clk);
        rst = 1'b1;
        wait_clk(2);
        rst = 1'b0;
        chk("R11 cause cleared by reset", {31'd0, rst_cause}, 32'd0);
        rd(4'h0, rv); chk("R1 control after second reset", rv, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule